// File: doc/BRIEF.md
# Serial-Port Event Interrupt Aggregator

This block gathers twelve single-cycle event pulses from a serial port (six per direction) into a sticky status register. A matching enable register masks them onto one combined interrupt line. Three dedicated legacy lines are driven alongside it. Each legacy line follows one status bit: receive ready, transmit ready, and receive overflow. The legacy lines are not masked.

Software reaches both registers through a plain single-cycle register port. The port has a write strobe, a one-bit register select, write data and combinational read data. The port never stalls and has no handshake, so it applies no back-pressure.

Status bits are cleared by writing ones to them. A bit set by an event stays set until software clears it, whether or not its enable bit is set. This lets software poll the status register with all interrupts masked.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, the status register and the enable register both read 0, and all four interrupt outputs are low.
- R2: A one-cycle pulse on event bit i sets status bit i at the next clock edge, whatever the enable bit.
  - Receive events use bits 0 to 5, in this order: overflow, underflow, ready, end of frame, frame sync, frame sync error.
  - Transmit events use bits 6 to 11, in the same order.
- R3: A write with select 0 clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, that bit stays set.
- R5: A write with select 1 loads the enable register, and a read with select 1 returns it. A read with select 0 returns the status register. A write with one select does not change the register behind the other select.
- R6: The combined line `irq_o` is high exactly when at least one status bit and its enable bit are both 1.
- R7: `leg_rx_irq_o` equals status bit 2 (receive ready), independent of the enable register.
- R8: `leg_tx_irq_o` equals status bit 8 (transmit ready), independent of the enable register.
- R9: `leg_rovf_irq_o` equals status bit 0 (receive overflow), independent of the enable register.
- R10: Receive underflow (bit 1) and transmit overflow (bit 6) raise `irq_o` only while their own enable bits are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 12 | Single-cycle event pulses, one bit per source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 status, 1 enable |
| reg_wdata_i | input | 12 | Write data (ones clear status bits when select is 0) |
| reg_rdata_o | output | 12 | Read data of the selected register |
| irq_o | output | 1 | Combined masked interrupt |
| leg_rx_irq_o | output | 1 | Legacy receive line |
| leg_tx_irq_o | output | 1 | Legacy transmit line |
| leg_rovf_irq_o | output | 1 | Legacy receive-overflow line |

## Verification
The assertions rely on a few properties of the inputs:
- Event inputs are clean one-cycle pulses.
- A write strobe carries stable select and data within its cycle.
- Reset is asserted for at least one clock edge before the properties are checked.

The bench drives every input at the falling edge and clears strobes and events after each rising edge. No pulse is ever longer than one cycle. Simultaneous event and clear traffic on the same bit is produced on purpose to exercise the set-wins rule.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned EVTS_PER_DIR = 6;
  localparam int unsigned NUM_DIRS     = 2;
  localparam int unsigned NUM_EVTS     = EVTS_PER_DIR * NUM_DIRS;
  localparam int unsigned RX_BASE      = 0;
  localparam int unsigned TX_BASE      = EVTS_PER_DIR;
  // per-direction offsets
  localparam int unsigned OFS_OVF   = 0;
  localparam int unsigned OFS_UNF   = 1;
  localparam int unsigned OFS_RDY   = 2;
  localparam int unsigned OFS_EOF   = 3;
  localparam int unsigned OFS_FS    = 4;
  localparam int unsigned OFS_FSERR = 5;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/evt_status_reg.sv
module evt_status_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)        stat_q[i] <= 1'b0;
      else if (evt_i[i]) stat_q[i] <= 1'b1;  // set wins over clear
      else if (clr_i[i]) stat_q[i] <= 1'b0;
    end

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[i] |=> stat_q[i]);  // R2
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i[i] && clr_i[i]) |=> stat_q[i]);  // R4
    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !evt_i[i]) |=> !stat_q[i]);  // R3
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[i] && !clr_i[i]) |=> stat_q[i]);  // R3
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/evt_enable_reg.sv
module evt_enable_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    en_q <= '0;
    else if (wr_i) en_q <= wdata_i;
  end

  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (en_q == $past(wdata_i)));  // R5
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(en_q));  // R5

  assign en_o = en_q;
endmodule

// File: rtl/evt_irq_combine.sv
module evt_irq_combine #(
  parameter int unsigned W       = 12,
  parameter int unsigned IDX_RX_RDY = 2,
  parameter int unsigned IDX_TX_RDY = 8,
  parameter int unsigned IDX_RX_OVF = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] en_i,
  output logic         irq_o,
  output logic         leg_rx_o,
  output logic         leg_tx_o,
  output logic         leg_rovf_o
);
  logic [W-1:0] pend;

  assign pend       = stat_i & en_i;
  assign irq_o      = |pend;
  assign leg_rx_o   = stat_i[IDX_RX_RDY];
  assign leg_tx_o   = stat_i[IDX_TX_RDY];
  assign leg_rovf_o = stat_i[IDX_RX_OVF];

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |-> !irq_o);  // R6
  AST_IRQ_NEEDS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_i == '0) |-> !(irq_o || leg_rx_o || leg_tx_o || leg_rovf_o));  // R6
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned PER_DIR = evt_irq_pkg::EVTS_PER_DIR
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*PER_DIR-1:0] evt_i,
  input  logic                 reg_wr_i,
  input  logic                 reg_sel_i,
  input  logic [2*PER_DIR-1:0] reg_wdata_i,
  output logic [2*PER_DIR-1:0] reg_rdata_o,
  output logic                 irq_o,
  output logic                 leg_rx_irq_o,
  output logic                 leg_tx_irq_o,
  output logic                 leg_rovf_irq_o
);
  localparam int unsigned W      = 2 * PER_DIR;
  localparam int unsigned TX_OFS = PER_DIR;

  reg_sel_e     sel;
  logic [W-1:0] clr, stat, en;
  logic         en_wr;

  assign sel   = reg_sel_e'(reg_sel_i);
  assign clr   = (reg_wr_i && sel == SEL_STATUS) ? reg_wdata_i : '0;
  assign en_wr = reg_wr_i && (sel == SEL_ENABLE);

  evt_status_reg #(.W(W)) u_status (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(clr), .stat_o(stat)
  );

  evt_enable_reg #(.W(W)) u_enable (
    .clk(clk), .rst_n(rst_n), .wr_i(en_wr), .wdata_i(reg_wdata_i), .en_o(en)
  );

  evt_irq_combine #(
    .W(W),
    .IDX_RX_RDY(OFS_RDY),
    .IDX_TX_RDY(TX_OFS + OFS_RDY),
    .IDX_RX_OVF(OFS_OVF)
  ) u_combine (
    .clk(clk), .rst_n(rst_n), .stat_i(stat), .en_i(en),
    .irq_o(irq_o), .leg_rx_o(leg_rx_irq_o), .leg_tx_o(leg_tx_irq_o),
    .leg_rovf_o(leg_rovf_irq_o)
  );

  assign reg_rdata_o = (sel == SEL_ENABLE) ? en : stat;

  AST_STAT_WR_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && sel == SEL_STATUS) |=> $stable(en));  // R5
  AST_EN_WR_KEEPS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && sel == SEL_ENABLE && evt_i == '0) |=> $stable(stat));  // R5
  AST_UNF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0 && stat[OFS_UNF] && stat[TX_OFS + OFS_OVF]) |-> !irq_o);  // R10
endmodule

// File: tb/evt_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module evt_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] evt = '0;
  logic        wr = 1'b0;
  logic        sel = 1'b0;
  logic [11:0] wdata = '0;
  logic [11:0] rdata;
  logic        irq, leg_rx, leg_tx, leg_rovf;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  evt_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_wr_i(wr), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
    .leg_rx_irq_o(leg_rx), .leg_tx_irq_o(leg_tx), .leg_rovf_irq_o(leg_rovf)
  );

  typedef struct packed {
    logic [11:0] evt;
    logic        wr;
    logic        sel;
    logic [11:0] wdata;
    logic [11:0] exp_stat;
    logic        exp_irq;
    logic [2:0]  exp_leg;  // {rovf, tx, rx}
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{12'h004, 1'b0, 1'b0, 12'h000, 12'h004, 1'b0, 3'b001},  // R2 R7
    '{12'h101, 1'b0, 1'b0, 12'h000, 12'h105, 1'b0, 3'b111},  // R8 R9
    '{12'h000, 1'b1, 1'b1, 12'h001, 12'h105, 1'b1, 3'b111},  // R6
    '{12'h000, 1'b1, 1'b0, 12'h001, 12'h104, 1'b0, 3'b011},  // R3
    '{12'h000, 1'b1, 1'b0, 12'h000, 12'h104, 1'b0, 3'b011},  // R3
    '{12'h002, 1'b0, 1'b0, 12'h000, 12'h106, 1'b0, 3'b011},  // R10
    '{12'h000, 1'b1, 1'b1, 12'h042, 12'h106, 1'b1, 3'b011},  // R10
    '{12'h000, 1'b1, 1'b0, 12'h106, 12'h000, 1'b0, 3'b000},  // R3
    '{12'h040, 1'b0, 1'b0, 12'h000, 12'h040, 1'b1, 3'b000},  // R10
    '{12'h800, 1'b1, 1'b0, 12'h040, 12'h800, 1'b0, 3'b000},  // R3 R6
    '{12'h800, 1'b1, 1'b0, 12'h800, 12'h800, 1'b0, 3'b000},  // R4
    '{12'h000, 1'b1, 1'b0, 12'h800, 12'h000, 1'b0, 3'b000}   // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at negedge, take one rising edge, release strobes, settle
  task automatic step(input logic [11:0] e, input logic w, input logic s, input logic [11:0] d);
    @(negedge clk);
    evt = e; wr = w; sel = s; wdata = d;
    @(posedge clk);
    #2;
    evt = '0; wr = 1'b0; sel = 1'b0; wdata = '0;
    #1;
  endtask

  initial begin : watchdog
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 status", {20'h0, rdata}, 32'h0);
    sel = 1'b1; #1;
    chk("R1 enable", {20'h0, rdata}, 32'h0);
    sel = 1'b0; #1;
    chk("R1 lines", {28'h0, irq, leg_rovf, leg_tx, leg_rx}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      step(TBL[k].evt, TBL[k].wr, TBL[k].sel, TBL[k].wdata);
      chk("R2/R3/R4 status vec", {20'h0, rdata}, {20'h0, TBL[k].exp_stat});
      chk("R6/R10 irq vec", {31'h0, irq}, {31'h0, TBL[k].exp_irq});
      chk("R7/R8/R9 legacy vec", {29'h0, leg_rovf, leg_tx, leg_rx}, {29'h0, TBL[k].exp_leg});
    end

    // R5 enable readback and isolation
    sel = 1'b1; #1;
    chk("R5 enable readback", {20'h0, rdata}, 32'h042);
    step(12'h000, 1'b1, 1'b0, 12'hFFF);
    sel = 1'b1; #1;
    chk("R5 status write keeps enable", {20'h0, rdata}, 32'h042);
    sel = 1'b0;
    step(12'h208, 1'b0, 1'b0, 12'h000);
    step(12'h000, 1'b1, 1'b1, 12'hFFF);
    chk("R5 enable write keeps status", {20'h0, rdata}, 32'h208);
    chk("R6 all enabled", {31'h0, irq}, 32'h1);

    // R2 every source sets its own bit, all masked
    step(12'h000, 1'b1, 1'b1, 12'h000);
    step(12'h000, 1'b1, 1'b0, 12'hFFF);
    for (int b = 0; b < 12; b++) begin
      step(12'h001 << b, 1'b0, 1'b0, 12'h000);
      chk("R2 single source", {20'h0, rdata}, {20'h0, 12'h001 << b});
      chk("R6 masked no irq", {31'h0, irq}, 32'h0);
      step(12'h000, 1'b1, 1'b0, 12'h001 << b);
    end

    // R1 mid-run reset clears everything
    step(12'hFFF, 1'b0, 1'b0, 12'h000);
    step(12'h000, 1'b1, 1'b1, 12'hFFF);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #2; rst_n = 1'b1; #1;
    chk("R1 status after reset", {20'h0, rdata}, 32'h0);
    sel = 1'b1; #1;
    chk("R1 enable after reset", {20'h0, rdata}, 32'h0);
    sel = 1'b0; #1;
    chk("R1 lines after reset", {28'h0, irq, leg_rovf, leg_tx, leg_rx}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule